// File: doc/BRIEF.md
# LIN Slave Frame Response Controller

This block sits between a byte-level LIN receiver/transmitter and a host that decides, frame by frame, what the slave does. It follows a frame header (break, sync byte, protected identifier). Once the identifier arrives, it raises a data request and an interrupt, then waits. The host inspects the identifier and answers in one of two ways. It can acknowledge, giving a direction and a length, and for transmit frames it first loads the payload into the buffer. Or it can stop, which tells the block to ignore the rest of the frame.

After an acknowledge, the block receives or sends the response bytes and then the checksum. It reports completion, a sync error, a timeout or a checksum error through sticky flags and one interrupt line. The timing of the host's answer matters. A transmit acknowledge must arrive within a configurable response window. A receive acknowledge must arrive before the first data byte, or that byte lands in buffer slot 0 and the frame is declared timed out.

Bit timing, baud recovery and the line driver are outside the block. Bytes arrive as single-cycle strobes, and outgoing bytes use a valid/ready handshake.

Top module: `lin_slave_resp`

## Requirements
- R1: After `rx_break`, a received byte 8'h55 and then a further byte, `data_req` and `irq` become 1 and `frame_id` shows that last byte.
- R2: If the byte after the break is not 8'h55, `err_flags[0]` (sync error) and `irq` are set and no request is raised.
- R3: An acknowledge with `host_dir`=0 stores the next N received bytes in buffer slots 0..N-1 and compares the following byte against the checksum; on a match `xfer_done` and `irq` become 1.
- R4: An acknowledge with `host_dir`=1 sends buffer slots 0..N-1 and then the checksum on `tx_data`; `tx_valid` and `tx_data` hold until `tx_ready`, and `xfer_done` is set after the checksum byte is accepted.
- R5: A length code 4'hF takes N from identifier bits [5:4]: 00 and 01 give 2, 10 gives 4, 11 gives 8; any other code is the byte count itself.
- R6: With `cfg_enh`=0 the checksum is the bitwise inverse of the 8-bit sum of the data bytes, each carry out of bit 7 added back in; with `cfg_enh`=1 the identifier byte is summed as well; a received mismatch sets `err_flags[2]`.
- R7: `host_stop` while a request is pending clears `data_req` and makes the block ignore all bytes until the next break.
- R8: A byte received while a request is pending and before the acknowledge is written into buffer slot 0, sets `err_flags[1]` (timeout) and `irq`, and ends the frame.
- R9: A transmit acknowledge arriving RSP_SPACE or more cycles after the request sends nothing and sets `err_flags[1]`.
- R10: A change of `cfg_enh` or `cfg_slave` during a frame abandons it without an error flag; a later acknowledge has no effect.
- R11: `clr_irq` clears `irq`, `clr_err` clears `err_flags`, and `xfer_done` clears at the next break.
- R12: Host buffer writes take effect, and `host_rdata` and `frame_id` show data, only while `data_req` is 1 or `bus_active` is 0; otherwise writes are dropped and both reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave | input | 1 | 1 selects slave operation; 0 holds the block idle |
| cfg_enh | input | 1 | 1 selects enhanced checksum |
| rx_break | input | 1 | One-cycle strobe: break detected on the bus |
| rx_valid | input | 1 | One-cycle strobe: `rx_data` holds a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte to send is present |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Transmitter accepts `tx_data` |
| host_ack | input | 1 | Acknowledge strobe |
| host_stop | input | 1 | Ignore-frame strobe |
| host_dir | input | 1 | Direction with acknowledge: 1 transmit, 0 receive |
| host_len | input | 4 | Length code; 4'hF decodes from identifier, codes above the depth saturate |
| host_we | input | 1 | Buffer write strobe |
| host_addr | input | 3 | Buffer write slot |
| host_wdata | input | 8 | Buffer write data |
| host_raddr | input | 3 | Buffer read slot |
| host_rdata | output | 8 | Buffer read data (gated) |
| frame_id | output | 8 | Captured identifier (gated) |
| bus_active | output | 1 | A frame is in progress |
| data_req | output | 1 | Identifier captured, host answer pending |
| xfer_done | output | 1 | Last response completed correctly |
| irq | output | 1 | Sticky interrupt request |
| err_flags | output | 3 | Sticky: [0] sync, [1] timeout, [2] checksum |
| clr_irq | input | 1 | Clear strobe for `irq` |
| clr_err | input | 1 | Clear strobe for `err_flags` |

## Verification
The hardest state to reach is a pending request during which some other event overtakes the host. There are three such events: the response window running out before a transmit acknowledge, a data byte arriving before a receive acknowledge, and the checksum mode flipping mid-frame. The stimulus builds a full header and then deliberately withholds the acknowledge. It either idles past the window, injects the data byte, or toggles `cfg_enh` while `data_req` is high. It then checks that the late acknowledge moves no bytes and that the right flag, or no flag, appears.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_PID, ST_WAIT, ST_RX, ST_RXCS, ST_TX, ST_TXCS
  } lin_st_e;

  localparam logic [7:0] SYNC_PATTERN = 8'h55;
  localparam logic [3:0] LEN_FROM_ID  = 4'hF;

  // byte count implied by identifier bits [5:4]
  function automatic int id_len(input logic [7:0] pid);
    case (pid[5:4])
      2'b10:   return 4;
      2'b11:   return 8;
      default: return 2;
    endcase
  endfunction

  // 8-bit addition with end-around carry
  function automatic logic [7:0] wrap_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction

endpackage

// File: rtl/lin_resp_buf.sv
module lin_resp_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsm_we,
  input  logic [AW-1:0] fsm_addr,
  input  logic [7:0]    fsm_wdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  input  logic [AW-1:0] rd_a_addr,
  output logic [7:0]    rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [7:0]    rd_b_data
);

  logic [7:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic       hit_f;
    logic       hit_h;
    logic [7:0] q;
    assign hit_f = fsm_we  && (fsm_addr  == AW'(i));
    assign hit_h = host_we && (host_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (hit_f) q <= fsm_wdata;
      else if (hit_h) q <= host_wdata;
    end
    assign slot[i] = q;
  end

  assign rd_a_data = slot[rd_a_addr];
  assign rd_b_data = slot[rd_b_addr];

endmodule

// File: rtl/lin_resp_csum.sv
module lin_resp_csum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic [7:0] init_val,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] sum
);
  import lin_resp_pkg::*;

  logic [7:0] acc_q;
  logic [7:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (init)     acc_d = init_val;
    else if (add) acc_d = wrap_add(acc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc_q <= '0;
    else if (init || add)  acc_q <= acc_d;
  end

  assign sum = acc_q;

endmodule

// File: rtl/lin_slave_resp.sv
module lin_slave_resp #(
  parameter int BUF_DEPTH = 8,
  parameter int RSP_SPACE = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_slave,
  input  logic       cfg_enh,
  input  logic       rx_break,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       host_ack,
  input  logic       host_stop,
  input  logic       host_dir,
  input  logic [3:0] host_len,
  input  logic       host_we,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic [2:0] host_raddr,
  output logic [7:0] host_rdata,
  output logic [7:0] frame_id,
  output logic       bus_active,
  output logic       data_req,
  output logic       xfer_done,
  output logic       irq,
  output logic [2:0] err_flags,
  input  logic       clr_irq,
  input  logic       clr_err
);
  import lin_resp_pkg::*;

  localparam int AW  = $clog2(BUF_DEPTH);
  localparam int CW  = $clog2(BUF_DEPTH + 1);
  localparam int RCW = $clog2(RSP_SPACE + 1);
  localparam int E_SYNC = 0;
  localparam int E_TMO  = 1;
  localparam int E_CS   = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  lin_st_e        st_q, st_d;
  logic [7:0]     pid_q, pid_d;
  logic           dreq_q, dreq_d;
  logic [CW-1:0]  idx_q, idx_d, n_q, n_d;
  logic           late_q, late_d;
  logic [RCW-1:0] cnt_q, cnt_d;
  logic           done_q, irq_q;
  logic [2:0]     err_q;
  logic           enh_q, slave_q;

  logic           irq_set, done_set, done_clr;
  logic [2:0]     err_set;
  logic           cs_init, cs_add;
  logic [7:0]     cs_init_val, cs_din, cs_sum;
  logic           fsm_we;
  logic [AW-1:0]  fsm_addr;
  logic [7:0]     buf_rd, host_rd;
  logic           host_ok, cfg_chg;
  logic [CW-1:0]  eff_len;

  always_comb begin
    int l;
    if (host_len == LEN_FROM_ID)    l = id_len(pid_q);
    else if (int'(host_len) > BUF_DEPTH) l = BUF_DEPTH;
    else                            l = int'(host_len);
    eff_len = CW'(l);
  end

  assign cfg_chg = (cfg_enh != enh_q) || (cfg_slave != slave_q);

  // next-state logic
  always_comb begin
    st_d        = st_q;
    pid_d       = pid_q;
    dreq_d      = dreq_q;
    idx_d       = idx_q;
    n_d         = n_q;
    late_d      = late_q;
    cnt_d       = cnt_q;
    irq_set     = 1'b0;
    done_set    = 1'b0;
    done_clr    = 1'b0;
    err_set     = 3'b000;
    cs_init     = 1'b0;
    cs_init_val = 8'h00;
    cs_add      = 1'b0;
    cs_din      = rx_data;
    fsm_we      = 1'b0;
    fsm_addr    = idx_q[AW-1:0];
    if (!cfg_slave || (cfg_chg && st_q != ST_IDLE)) begin
      st_d   = ST_IDLE;
      dreq_d = 1'b0;
    end else if (rx_break) begin
      st_d     = ST_SYNC;
      dreq_d   = 1'b0;
      done_clr = 1'b1;
    end else begin
      case (st_q)
        ST_SYNC: if (rx_valid) begin
          if (rx_data == SYNC_PATTERN) st_d = ST_PID;
          else begin
            err_set[E_SYNC] = 1'b1;
            irq_set         = 1'b1;
            st_d            = ST_IDLE;
          end
        end
        ST_PID: if (rx_valid) begin
          pid_d   = rx_data;
          dreq_d  = 1'b1;
          irq_set = 1'b1;
          cnt_d   = '0;
          late_d  = 1'b0;
          st_d    = ST_WAIT;
        end
        ST_WAIT: begin
          if (!late_q) begin
            if (cnt_q == RCW'(RSP_SPACE - 1)) late_d = 1'b1;
            else                              cnt_d  = cnt_q + 1'b1;
          end
          if (host_stop) begin
            dreq_d = 1'b0;
            st_d   = ST_IDLE;
          end else if (rx_valid) begin
            fsm_we         = 1'b1;
            fsm_addr       = '0;
            err_set[E_TMO] = 1'b1;
            irq_set        = 1'b1;
            dreq_d         = 1'b0;
            st_d           = ST_IDLE;
          end else if (host_ack) begin
            dreq_d      = 1'b0;
            n_d         = eff_len;
            idx_d       = '0;
            cs_init     = 1'b1;
            cs_init_val = cfg_enh ? pid_q : 8'h00;
            if (host_dir) begin
              if (late_q) begin
                err_set[E_TMO] = 1'b1;
                irq_set        = 1'b1;
                st_d           = ST_IDLE;
              end else begin
                st_d = (eff_len == '0) ? ST_TXCS : ST_TX;
              end
            end else begin
              st_d = (eff_len == '0) ? ST_RXCS : ST_RX;
            end
          end
        end
        ST_RX: if (rx_valid) begin
          fsm_we = 1'b1;
          cs_add = 1'b1;
          idx_d  = idx_q + 1'b1;
          if (idx_q == n_q - 1'b1) st_d = ST_RXCS;
        end
        ST_RXCS: if (rx_valid) begin
          irq_set = 1'b1;
          if (rx_data == ~cs_sum) done_set = 1'b1;
          else                    err_set[E_CS] = 1'b1;
          st_d = ST_IDLE;
        end
        ST_TX: begin
          cs_din = buf_rd;
          if (tx_ready) begin
            cs_add = 1'b1;
            idx_d  = idx_q + 1'b1;
            if (idx_q == n_q - 1'b1) st_d = ST_TXCS;
          end
        end
        ST_TXCS: if (tx_ready) begin
          done_set = 1'b1;
          irq_set  = 1'b1;
          st_d     = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pid_q   <= '0;
      dreq_q  <= 1'b0;
      idx_q   <= '0;
      n_q     <= '0;
      late_q  <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= '0;
      enh_q   <= 1'b0;
      slave_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pid_q   <= pid_d;
      dreq_q  <= dreq_d;
      idx_q   <= idx_d;
      n_q     <= n_d;
      late_q  <= late_d;
      cnt_q   <= cnt_d;
      enh_q   <= cfg_enh;
      slave_q <= cfg_slave;
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (irq_set)       irq_q  <= 1'b1;
      else if (clr_irq)  irq_q  <= 1'b0;
      if (clr_err || (err_set != 3'b000)) err_q <= (clr_err ? 3'b000 : err_q) | err_set;
    end
  end

  lin_resp_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_ni),
    .fsm_we    (fsm_we),
    .fsm_addr  (fsm_addr),
    .fsm_wdata (rx_data),
    .host_we   (host_we && host_ok),
    .host_addr (host_addr[AW-1:0]),
    .host_wdata(host_wdata),
    .rd_a_addr (idx_q[AW-1:0]),
    .rd_a_data (buf_rd),
    .rd_b_addr (host_raddr[AW-1:0]),
    .rd_b_data (host_rd)
  );

  lin_resp_csum u_csum (
    .clk     (clk),
    .rst_n   (rst_ni),
    .init    (cs_init),
    .init_val(cs_init_val),
    .add     (cs_add),
    .din     (cs_din),
    .sum     (cs_sum)
  );

  assign bus_active = (st_q != ST_IDLE);
  assign host_ok    = dreq_q || !bus_active;
  assign host_rdata = host_ok ? host_rd : 8'h00;
  assign frame_id   = host_ok ? pid_q : 8'h00;
  assign tx_valid   = (st_q == ST_TX) || (st_q == ST_TXCS);
  assign tx_data    = (st_q == ST_TXCS) ? ~cs_sum : buf_rd;
  assign data_req   = dreq_q;
  assign xfer_done  = done_q;
  assign irq        = irq_q;
  assign err_flags  = err_q;

endmodule

// File: rtl/lin_slave_resp_chk.sv
module lin_slave_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_slave,
  input logic       cfg_enh,
  input logic       rx_break,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       host_stop,
  input logic       data_req,
  input logic       xfer_done,
  input logic       irq,
  input logic [2:0] err_flags
);

  AST_REQ_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_req) |-> irq); // R1

  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_flags & ~$past(err_flags))) |-> irq); // R2

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> irq); // R3

  AST_NO_TX_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> !tx_valid); // R4

  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || $stable(tx_data))); // R4

  AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && host_stop) |=> (!data_req && !tx_valid)); // R7

  AST_MODE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_enh != $past(cfg_enh)) || (cfg_slave != $past(cfg_slave)))
      |=> (!data_req && !tx_valid)); // R10

  logic unused_ok;
  assign unused_ok = rx_break;

endmodule

bind lin_slave_resp lin_slave_resp_chk u_chk (.*);

// File: tb/tb_lin_slave_resp.sv
module tb_lin_slave_resp;

  localparam int RSP = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_slave, cfg_enh, rx_break, rx_valid;
  logic [7:0] rx_data;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       host_ack, host_stop, host_dir, host_we;
  logic [3:0] host_len;
  logic [2:0] host_addr, host_raddr;
  logic [7:0] host_wdata, host_rdata, frame_id;
  logic       bus_active, data_req, xfer_done, irq, clr_irq, clr_err;
  logic [2:0] err_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] pay [8];
  logic [7:0] tx_log [16];
  int tx_cnt = 0;

  always #2 clk = ~clk;

  lin_slave_resp #(.BUF_DEPTH(8), .RSP_SPACE(RSP)) dut (.*);

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      if (tx_cnt < 16) tx_log[tx_cnt] = tx_data;
      tx_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_cs(input int seed, input int n);
    int s = seed;
    for (int i = 0; i < n; i++) begin
      s = s + pay[i];
      if (s > 255) s = s - 255;
    end
    return ~s[7:0];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic header(input logic [7:0] pid);
    brk(); send(8'h55); send(pid);
  endtask

  task automatic ack(input logic dir, input logic [3:0] len);
    @(negedge clk); host_ack = 1'b1; host_dir = dir; host_len = len;
    @(negedge clk); host_ack = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk); host_stop = 1'b1;
    @(negedge clk); host_stop = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_raddr = a; #1; d = host_rdata;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_irq = 1'b1; clr_err = 1'b1;
    @(negedge clk); clr_irq = 1'b0; clr_err = 1'b0;
  endtask

  task automatic t_reset();
    chk(!data_req && !irq && !xfer_done && !tx_valid && !bus_active, "R11 reset idle", {data_req, irq, xfer_done, tx_valid}, 0);
    chk(err_flags == 3'b000, "R11 reset errors", err_flags, 0);
  endtask

  task automatic t_header();
    header(8'h3C);
    chk(data_req && irq, "R1 request and irq", {data_req, irq}, 3);
    chk(frame_id == 8'h3C, "R1 frame_id", frame_id, 8'h3C);
    stop(); clear_all();
  endtask

  task automatic t_sync_err();
    brk(); send(8'h00);
    chk(err_flags == 3'b001 && irq, "R2 sync error", err_flags, 1);
    chk(!data_req, "R2 no request", data_req, 0);
    clear_all();
  endtask

  task automatic t_rx_classic();
    logic [7:0] v;
    pay[0] = 8'h12; pay[1] = 8'h34;
    header(8'h10); clear_all();
    ack(1'b0, 4'd2);
    send(pay[0]); send(pay[1]); send(ref_cs(0, 2));
    chk(xfer_done && irq && err_flags == 0, "R3 rx done", {xfer_done, irq, err_flags}, 6'h30);
    rd(3'd0, v); chk(v == 8'h12, "R3 slot0", v, 8'h12);
    rd(3'd1, v); chk(v == 8'h34, "R3 slot1", v, 8'h34);
    chk(ref_cs(0, 2) == 8'hB9, "R6 classic value", ref_cs(0, 2), 8'hB9);
    brk();
    chk(!xfer_done, "R11 done cleared by break", xfer_done, 0);
    clear_all();
  endtask

  task automatic t_rx_bad_cs();
    pay[0] = 8'h40;
    header(8'h01); clear_all();
    ack(1'b0, 4'd1);
    send(pay[0]); send(ref_cs(0, 1) ^ 8'h01);
    chk(err_flags == 3'b100 && !xfer_done && irq, "R6 checksum error", err_flags, 4);
    clear_all();
    chk(err_flags == 0 && !irq, "R11 clear strobes", {irq, err_flags}, 0);
  endtask

  task automatic t_tx_enh();
    logic [7:0] exp;
    cfg_enh = 1'b1; cyc(2);
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03; pay[3] = 8'hFF;
    header(8'hA5); clear_all();
    for (int i = 0; i < 4; i++) wr(3'(i), pay[i]);
    tx_ready = 1'b0; tx_cnt = 0;
    ack(1'b1, 4'hF);
    cyc(3);
    chk(tx_valid && tx_data == 8'h01 && tx_cnt == 0, "R4 holds without ready", tx_data, 8'h01);
    tx_ready = 1'b1;
    cyc(12);
    chk(tx_cnt == 5, "R5 decoded length 4 plus checksum", tx_cnt, 5);
    for (int i = 0; i < 4; i++) chk(tx_log[i] == pay[i], "R4 payload byte", tx_log[i], pay[i]);
    exp = ref_cs(8'hA5, 4);
    chk(tx_log[4] == exp, "R6 enhanced checksum", tx_log[4], exp);
    chk(xfer_done && irq, "R4 tx done", {xfer_done, irq}, 3);
    cfg_enh = 1'b0; cyc(2); clear_all();
  endtask

  task automatic t_stop();
    header(8'h22); stop(); clear_all();
    chk(!data_req, "R7 request dropped", data_req, 0);
    send(8'h55); send(8'h11); send(8'h22); send(8'h33);
    chk(!irq && !xfer_done && err_flags == 0 && !data_req, "R7 bytes ignored", {irq, xfer_done, err_flags}, 0);
    header(8'h22);
    chk(data_req, "R7 next break resumes", data_req, 1);
    stop(); clear_all();
  endtask

  task automatic t_rx_timeout();
    logic [7:0] v;
    header(8'h05); clear_all();
    send(8'h99);
    chk(err_flags == 3'b010 && irq && !data_req, "R8 rx timeout", err_flags, 2);
    rd(3'd0, v); chk(v == 8'h99, "R8 byte overwrote slot0", v, 8'h99);
    ack(1'b0, 4'd2); clear_all();
  endtask

  task automatic t_tx_late();
    header(8'h06); clear_all(); tx_cnt = 0;
    cyc(RSP + 4);
    ack(1'b1, 4'd2);
    cyc(8);
    chk(tx_cnt == 0, "R9 no late response", tx_cnt, 0);
    chk(err_flags == 3'b010, "R9 timeout flag", err_flags, 2);
    clear_all();
  endtask

  task automatic t_mode();
    header(8'h07); clear_all(); tx_cnt = 0;
    @(negedge clk); cfg_enh = 1'b1;
    @(negedge clk);
    chk(!data_req && err_flags == 0, "R10 frame abandoned", {data_req, err_flags}, 0);
    cfg_enh = 1'b0; cyc(2);
    ack(1'b1, 4'd2); cyc(6);
    chk(tx_cnt == 0 && !xfer_done, "R10 ack ignored", tx_cnt, 0);
    clear_all();
  endtask

  task automatic t_gate();
    logic [7:0] v;
    wr(3'd3, 8'h5A);
    pay[0] = 8'h61; pay[1] = 8'h62;
    header(8'h00); clear_all();
    ack(1'b0, 4'd2);
    wr(3'd3, 8'hEE);
    rd(3'd3, v); chk(v == 8'h00, "R12 read gated", v, 0);
    chk(frame_id == 8'h00, "R12 id gated", frame_id, 0);
    send(pay[0]); send(pay[1]); send(ref_cs(0, 2));
    rd(3'd3, v); chk(v == 8'h5A, "R12 write dropped", v, 8'h5A);
    clear_all();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_slave = 1'b1; cfg_enh = 1'b0;
    rx_break = 0; rx_valid = 0; rx_data = 0; tx_ready = 1;
    host_ack = 0; host_stop = 0; host_dir = 0; host_len = 0;
    host_we = 0; host_addr = 0; host_wdata = 0; host_raddr = 0;
    clr_irq = 0; clr_err = 0;
    cyc(3); rst_n = 1'b1; cyc(4);
    t_reset();
    t_header();
    t_sync_err();
    t_rx_classic();
    t_rx_bad_cs();
    t_tx_enh();
    t_stop();
    t_rx_timeout();
    t_tx_late();
    t_mode();
    t_gate();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule